// File: doc/BRIEF.md
# Host Interrupt Status Controller

This block gathers single-cycle event pulses from up to sixteen internal sources into a pending vector. It combines that vector with a per-source mask and drives one interrupt line toward the host. Firmware-side logic raises the events. The host reaches the block through a small single-cycle register bus. On that bus it can write the mask whole, or set or clear chosen mask bits without a read-modify-write. It can look at the pending bits without disturbing them. It can also take them in one destructive read, or retire chosen bits by writing ones to an acknowledge location.

Two quasi-static strap inputs shape the line. One gates it on or off, and the other selects active-low signalling. The source positions are fixed by the event wiring: 0 first receive buffer, 1 transmit data, 2 transmit transfer, 3 second receive buffer, 4 receive transfer, 5 and 6 event mailboxes, 7 wake, 8 and 9 debug trace, 10 command complete, 14 initialization complete. The other positions are spare.

Register word addresses on `bus_addr`: 0 mask (read/write), 1 mask-set (write only), 2 mask-clear (write only), 3 status peek (read only), 4 status take (read only, clears on read), 5 acknowledge (write only). Addresses 6 and 7 are unused.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the mask reads 0x0001 (only source 0 masked), the pending vector is all zero, and the interrupt line sits at its inactive level.
- R2: A write to address 0 loads the whole mask, and a read of address 0 returns the mask in the same cycle.
- R3: A write to address 1 sets each mask bit whose data bit is 1 and leaves the other mask bits as they were.
- R4: A write to address 2 clears each mask bit whose data bit is 1 and leaves the other mask bits as they were.
- R5: A read of address 3 returns the pending vector and leaves it unchanged.
- R6: A read of address 4 returns the pending vector, and at the end of that cycle every pending bit is cleared.
- R7: A write to address 5 clears each pending bit whose data bit is 1. Data bits of 0 have no effect.
- R8: An event arriving on a bit in the same cycle as a clear of that bit (take read or acknowledge) leaves the bit pending.
- R9: The line state is registered. In the cycle after pending and mask show any bit pending and unmasked while the enable strap is 1, the line is active, and otherwise it is inactive. With the enable strap at 0 the line stays inactive.
- R10: With the polarity strap at 0 the active level is 1. With the polarity strap at 1 the active level is 0 and the inactive level is 1.
- R11: Reads of write-only or unused addresses return 0. Writes to read-only or unused addresses change neither mask nor pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 16 | Event pulses, one bit per source |
| strap_irq_en | input | 1 | Enables the host interrupt line |
| strap_irq_low | input | 1 | Selects active-low signalling on the line |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the access cycle |
| irq_o | output | 1 | Host interrupt line |

## Verification
The assertions assume at most one register access per cycle, with address and direction stable for that cycle. They also assume the straps change only between accesses and never toward an unknown value. Events may arrive on any bit in any cycle, including the cycle of a take read or an acknowledge. The stimulus follows these assumptions. It drives one access per cycle from tasks, and changes the straps only in idle cycles. It sends sparse random event bursts that often land on the same bits being acknowledged or taken, so the event-wins rule is exercised many times.

// File: rtl/irqs_pkg.sv
package irqs_pkg;

  localparam int unsigned IRQS_MAXW = 32;
  typedef logic [IRQS_MAXW-1:0] vec_t;

  typedef enum logic [2:0] {
    RA_MASK = 3'd0,
    RA_MSET = 3'd1,
    RA_MCLR = 3'd2,
    RA_PEEK = 3'd3,
    RA_TAKE = 3'd4,
    RA_ACK  = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic mask_rd;
    logic mask_wr;
    logic mask_set;
    logic mask_clr;
    logic peek_rd;
    logic take_rd;
    logic ack_wr;
  } strobe_t;

  function automatic vec_t mask_next(vec_t cur, vec_t wd, strobe_t s);
    vec_t r;
    r = cur;
    if (s.mask_wr)       r = wd;
    else if (s.mask_set) r = cur | wd;
    else if (s.mask_clr) r = cur & ~wd;
    return r;
  endfunction

  function automatic vec_t pend_next(vec_t cur, vec_t ev, vec_t wd, strobe_t s);
    vec_t clr;
    clr = '0;
    if (s.take_rd)     clr = '1;
    else if (s.ack_wr) clr = wd;
    return (cur & ~clr) | ev;
  endfunction

  function automatic logic line_req(vec_t p, vec_t m, logic en);
    return en & (|(p & ~m));
  endfunction

endpackage

// File: rtl/irqs_decode.sv
module irqs_decode
  import irqs_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           stb
);
  function automatic logic hit(logic [ADDR_W-1:0] a, reg_addr_e r);
    return a == ADDR_W'(r);
  endfunction

  always_comb begin
    stb = '0;
    if (valid) begin
      stb.mask_rd  = !write && hit(addr, RA_MASK);
      stb.mask_wr  =  write && hit(addr, RA_MASK);
      stb.mask_set =  write && hit(addr, RA_MSET);
      stb.mask_clr =  write && hit(addr, RA_MCLR);
      stb.peek_rd  = !write && hit(addr, RA_PEEK);
      stb.take_rd  = !write && hit(addr, RA_TAKE);
      stb.ack_wr   =  write && hit(addr, RA_ACK);
    end
  end
endmodule

// File: rtl/irqs_mask_reg.sv
module irqs_mask_reg
  import irqs_pkg::*;
#(
  parameter int          W   = 16,
  parameter logic [W-1:0] RST = W'(1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  strobe_t      stb,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask
);
  vec_t nxt;
  always_comb nxt = mask_next(vec_t'(mask), vec_t'(wdata), stb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= RST;
    else        mask <= nxt[W-1:0];
  end
endmodule

// File: rtl/irqs_pending.sv
module irqs_pending
  import irqs_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  strobe_t      stb,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pend
);
  vec_t nxt;
  always_comb nxt = pend_next(vec_t'(pend), vec_t'(evt), vec_t'(wdata), stb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= nxt[W-1:0];
  end
endmodule

// File: rtl/irqs_line.sv
module irqs_line
  import irqs_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pend,
  input  logic [W-1:0] mask,
  input  logic         en,
  input  logic         low,
  output logic         irq_q,
  output logic         irq_o
);
  logic req;
  always_comb req = line_req(vec_t'(pend), vec_t'(mask), en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= req;
  end

  assign irq_o = irq_q ^ low;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irqs_pkg::*;
#(
  parameter int           NUM_SRC  = 16,
  parameter int           ADDR_W   = 3,
  parameter logic [15:0]  MASK_RST = 16'h0001
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               strap_irq_en,
  input  logic               strap_irq_low,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [NUM_SRC-1:0] bus_wdata,
  output logic [NUM_SRC-1:0] bus_rdata,
  output logic               irq_o
);
  localparam logic [NUM_SRC-1:0] MASK_INIT = NUM_SRC'(MASK_RST);

  strobe_t            stb;
  logic [NUM_SRC-1:0] mask;
  logic [NUM_SRC-1:0] pend;
  logic               irq_q;

  irqs_decode #(.ADDR_W(ADDR_W)) u_dec (
    .valid (bus_valid),
    .write (bus_write),
    .addr  (bus_addr),
    .stb   (stb)
  );

  irqs_mask_reg #(.W(NUM_SRC), .RST(MASK_INIT)) u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .stb   (stb),
    .wdata (bus_wdata),
    .mask  (mask)
  );

  irqs_pending #(.W(NUM_SRC)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .stb   (stb),
    .evt   (evt_i),
    .wdata (bus_wdata),
    .pend  (pend)
  );

  irqs_line #(.W(NUM_SRC)) u_line (
    .clk   (clk),
    .rst_n (rst_n),
    .pend  (pend),
    .mask  (mask),
    .en    (strap_irq_en),
    .low   (strap_irq_low),
    .irq_q (irq_q),
    .irq_o (irq_o)
  );

  always_comb begin
    if (stb.mask_rd)                    bus_rdata = mask;
    else if (stb.peek_rd || stb.take_rd) bus_rdata = pend;
    else                                bus_rdata = '0;
  end
endmodule

// File: rtl/irqs_chk.sv
module irqs_chk
  import irqs_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input strobe_t      stb,
  input logic [W-1:0] wdata,
  input logic [W-1:0] evt,
  input logic [W-1:0] pend,
  input logic [W-1:0] mask,
  input logic         en,
  input logic         irq_q
);
  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    stb.mask_wr |=> mask == $past(wdata)); // R2

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    stb.mask_set |=> ((mask & $past(wdata)) == $past(wdata)) &&
                     ((mask & ~$past(wdata)) == ($past(mask) & ~$past(wdata)))); // R3

  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    stb.mask_clr |=> ((mask & $past(wdata)) == '0) &&
                     ((mask & ~$past(wdata)) == ($past(mask) & ~$past(wdata)))); // R4

  AST_PEEK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    stb.peek_rd |=> (pend & $past(pend)) == $past(pend)); // R5

  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stb.take_rd |=> pend == $past(evt)); // R6

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stb.ack_wr |=> (pend & $past(wdata) & ~$past(evt)) == '0); // R7

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> (pend & $past(evt)) == $past(evt)); // R8

  AST_LINE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_q == ($past(en) && (|($past(pend) & ~$past(mask))))); // R9
endmodule

bind irq_status_ctrl irqs_chk #(.W(NUM_SRC)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .stb   (stb),
  .wdata (bus_wdata),
  .evt   (evt_i),
  .pend  (pend),
  .mask  (mask),
  .en    (strap_irq_en),
  .irq_q (irq_q)
);

// File: tb/irq_status_ctrl_tb.sv
module irq_status_ctrl_tb;
  localparam int  W     = 16;
  localparam int  AW    = 3;
  localparam time CLK_P = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  evt_i = '0;
  logic          strap_irq_en = 1'b1;
  logic          strap_irq_low = 1'b0;
  logic          bus_valid = 1'b0;
  logic          bus_write = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;
  logic          irq_o;

  irq_status_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
    .strap_irq_en(strap_irq_en), .strap_irq_low(strap_irq_low),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  logic [W-1:0] m_mask, m_pend, rd;
  logic         m_irq;

  function automatic logic [W-1:0] exp_read(logic [AW-1:0] a);
    if (a == 3'd0) return m_mask;
    if (a == 3'd3 || a == 3'd4) return m_pend;
    return '0;
  endfunction

  function automatic logic [W-1:0] exp_mask(logic [W-1:0] m, bit w, logic [AW-1:0] a,
                                            logic [W-1:0] d);
    logic [W-1:0] r = m;
    if (!w) return r;
    for (int i = 0; i < W; i++) begin
      if (a == 3'd0) r[i] = d[i];
      if (a == 3'd1 && d[i]) r[i] = 1'b1;
      if (a == 3'd2 && d[i]) r[i] = 1'b0;
    end
    return r;
  endfunction

  function automatic logic [W-1:0] exp_pend(logic [W-1:0] p, bit w, logic [AW-1:0] a,
                                            logic [W-1:0] d, logic [W-1:0] e);
    logic [W-1:0] r = p;
    for (int i = 0; i < W; i++) begin
      if (!w && a == 3'd4) r[i] = 1'b0;
      if (w && a == 3'd5 && d[i]) r[i] = 1'b0;
      if (e[i]) r[i] = 1'b1;
    end
    return r;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(bit v, bit w, logic [AW-1:0] a, logic [W-1:0] d,
                     logic [W-1:0] e, string req, output logic [W-1:0] r);
    @(negedge clk);
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d; evt_i = e;
    #1;
    r = bus_rdata;
    if (v && !w) check(req, bus_rdata, exp_read(a));
    @(posedge clk);
    m_irq = strap_irq_en && (|(m_pend & ~m_mask));
    if (v) begin
      m_pend = exp_pend(m_pend, w, a, d, e);
      m_mask = exp_mask(m_mask, w, a, d);
    end else begin
      m_pend = m_pend | e;
    end
    #1;
    check("R9/R10 line", {15'd0, irq_o}, {15'd0, m_irq ^ strap_irq_low});
    bus_valid = 1'b0; evt_i = '0;
  endtask

  task automatic idle(logic [W-1:0] e);
    logic [W-1:0] r;
    cyc(1'b0, 1'b0, 3'd0, '0, e, "idle", r);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [W-1:0] r;
    void'($urandom(32'd20240611));
    m_mask = 16'h0001; m_pend = '0; m_irq = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 line at reset", {15'd0, irq_o}, 16'd0);
    rst_n = 1'b1;
    cyc(1, 0, 3'd0, '0, '0, "R1 mask reset", r);
    check("R1 mask value", r, 16'h0001);
    cyc(1, 0, 3'd3, '0, '0, "R1 pending reset", r);
    check("R1 pending value", r, 16'h0000);

    // R2 full mask write and read back
    cyc(1, 1, 3'd0, 16'hA5A5, '0, "R2", r);
    cyc(1, 0, 3'd0, '0, '0, "R2 readback", r);
    check("R2 literal", r, 16'hA5A5);
    // R3 set alias
    cyc(1, 1, 3'd1, 16'h0F00, '0, "R3", r);
    cyc(1, 0, 3'd0, '0, '0, "R3 readback", r);
    check("R3 literal", r, 16'hAFA5);
    // R4 clear alias
    cyc(1, 1, 3'd2, 16'h00A5, '0, "R4", r);
    cyc(1, 0, 3'd0, '0, '0, "R4 readback", r);
    check("R4 literal", r, 16'hAF00);
    // R11 writes to read-only addresses ignored, write-only reads zero
    cyc(1, 1, 3'd3, 16'hFFFF, '0, "R11", r);
    cyc(1, 1, 3'd4, 16'hFFFF, '0, "R11", r);
    cyc(1, 1, 3'd7, 16'hFFFF, '0, "R11", r);
    cyc(1, 0, 3'd0, '0, '0, "R11 mask kept", r);
    check("R11 mask literal", r, 16'hAF00);
    cyc(1, 0, 3'd3, '0, '0, "R11 pending kept", r);
    check("R11 pending literal", r, 16'h0000);
    cyc(1, 0, 3'd1, '0, '0, "R11 read set alias", r);
    cyc(1, 0, 3'd5, '0, '0, "R11 read ack", r);
    check("R11 ack reads zero", r, 16'h0000);

    // R5 peek is non-destructive, line follows unmasked pending
    cyc(1, 1, 3'd0, 16'h0000, '0, "R2", r);
    idle(16'h0005);
    idle('0);
    cyc(1, 0, 3'd3, '0, '0, "R5 first peek", r);
    cyc(1, 0, 3'd3, '0, '0, "R5 second peek", r);
    check("R5 literal", r, 16'h0005);
    // R6 take returns then clears
    cyc(1, 0, 3'd4, '0, '0, "R6 take", r);
    check("R6 literal", r, 16'h0005);
    cyc(1, 0, 3'd3, '0, '0, "R6 after take", r);
    check("R6 cleared", r, 16'h0000);
    // R8 event during take survives
    idle(16'h0300);
    cyc(1, 0, 3'd4, '0, 16'h0010, "R8 take", r);
    check("R8 take value", r, 16'h0300);
    cyc(1, 0, 3'd3, '0, '0, "R8 after take", r);
    check("R8 literal", r, 16'h0010);
    // R7 acknowledge, and R8 with acknowledge
    idle(16'h00E0);
    cyc(1, 1, 3'd5, 16'h0030, '0, "R7", r);
    cyc(1, 0, 3'd3, '0, '0, "R7 peek", r);
    check("R7 literal", r, 16'h00C0);
    cyc(1, 1, 3'd5, 16'h0040, 16'h0040, "R8 ack", r);
    cyc(1, 0, 3'd3, '0, '0, "R8 ack peek", r);
    check("R8 ack literal", r, 16'h00C0);
    // R9 masking blocks the line, enable strap gates it
    cyc(1, 1, 3'd1, 16'hFFFF, '0, "R9 mask all", r);
    idle('0);
    cyc(1, 1, 3'd2, 16'h0080, '0, "R9 unmask", r);
    idle('0);
    @(negedge clk); strap_irq_en = 1'b0;
    idle('0); idle('0);
    // R10 active-low polarity
    @(negedge clk); strap_irq_en = 1'b1; strap_irq_low = 1'b1;
    idle('0); idle('0);
    cyc(1, 0, 3'd4, '0, '0, "R10 take", r);
    idle('0); idle('0);
    @(negedge clk); strap_irq_low = 1'b0;
    idle('0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] a;
      logic [W-1:0]  d, e;
      bit            v, w;
      v = ($urandom % 4) != 0;
      w = $urandom % 2;
      a = AW'($urandom % 8);
      d = W'($urandom);
      e = (($urandom % 3) == 0) ? W'($urandom & $urandom) : '0;
      if (i % 500 == 499) begin
        @(negedge clk);
        strap_irq_low = $urandom % 2;
        strap_irq_en  = ($urandom % 4) != 0;
      end
      cyc(v, w, a, d, e, "R2-R8 random", r);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule